// File: doc/BRIEF.md
# PCI Base Address Register File

This block holds the seven address-decoding registers of a PCI type-0 configuration header: six base-address slots and the expansion ROM register. Software reaches them through a DWORD-wide configuration port with per-byte write enables. Each slot is given a kind and a power-of-two region size by parameters. The kind is unused, I/O, 32-bit memory, or 64-bit memory, and a 64-bit memory BAR takes its own slot plus the one after it. Type bits and address bits below the region size are fixed. Because of that, an all-ones sizing probe reads back the size mask without any special handling on the read side.

Alongside the register storage, the block tracks the last programmed base of every decoded region. When a write outside a probe moves a region to a different base, it raises a one-cycle relocation event. The event gives the register index, the old base, the new base and the region length. The surrounding logic can then update its address decoders. A 64-bit pair is judged as one 64-bit value, and only when its upper half is written.

Top module: `barfile_top`

## Requirements
- R1: After reset every slot reads back with a zero address field and only its fixed type bits set. With the default parameters, index 0 reads 0x0, index 1 reads 0x1, index 2 reads 0x4 and index 6 reads 0x0.
- R2: Type bits never change. An I/O slot reads bit 0 as 1 and bit 1 as 0. A 32-bit memory slot reads bits 3:0 as 0. The low half of a 64-bit memory slot reads bits 3:0 as 0x4.
- R3: Address bits below the region size always read as zero, whatever was written.
- R4: A write that leaves every writable address bit of a slot at 1 is a sizing probe. The next read returns the size mask with the type bits, and no relocation event follows.
- R5: A 64-bit pair (low half at index n, high half at n+1) is checked only when its high half is written, as the 64-bit value {high, low}. It is a probe only when both halves are all ones in their writable bits. If either half holds a real address, an all-ones half is part of that address and can cause a relocation.
- R6: The expansion ROM register sits at index 6. Bit 0 is a writable enable, bits 10:1 read as zero, and the address occupies bits 31 and down to the region size, never below bit 11. A write of 0xFFFFF800 is a probe and raises no event.
- R7: One cycle after a write that changes the committed base of a decoded region outside a probe, reloc_valid is high for that cycle. At the same time reloc_idx, reloc_old, reloc_new and reloc_len (the region size in bytes) are valid. A write that leaves the base unchanged raises no event.
- R8: An unused slot, and index 7, read as zero and never raise an event. Writes to them have no effect.
- R9: Byte enable bit b gates data bits 8b+7:8b. A partial write that leaves all writable address bits at 1 is a probe, exactly like a full all-ones write.
- R10: A read with cfg_rd high returns its data on rd_data with rd_valid high in the following cycle. rd_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | 3 | Register index: 0-5 base slots, 6 expansion ROM, 7 none |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| reloc_valid | output | 1 | One-cycle relocation event |
| reloc_idx | output | 3 | Index of the moved region (low slot of a pair) |
| reloc_old | output | 64 | Base before the move |
| reloc_new | output | 64 | Base after the move |
| reloc_len | output | 64 | Region length in bytes |

## Verification
The memory, I/O, 64-bit pair and ROM slots are each written with ordinary addresses that carry junk in their fixed bits. These writes separate correct masking from plain storage. The slots are also sent full all-ones probes and then restores of the old address, which show whether a probe is kept apart from a move and whether an unchanged base stays quiet. The 64-bit pair also gets an all-ones high half over a real low half, and an all-ones low half under a real high half. These two cases tell a per-half probe test from the combined one. Byte-lane writes that complete the all-ones pattern piece by piece, and writes to unused indices, show that the lanes are merged before the probe decision and that empty slots hold nothing.

// File: rtl/barfile_pkg.sv
package barfile_pkg;

  localparam int unsigned KIND_NONE  = 0;
  localparam int unsigned KIND_IO    = 1;
  localparam int unsigned KIND_MEM32 = 2;
  localparam int unsigned KIND_MEM64 = 3;

  localparam int unsigned ROM_MIN_LOG2 = 11;
  localparam int unsigned IO_MIN_LOG2  = 2;
  localparam int unsigned MEM_MIN_LOG2 = 4;

  // ones at bit positions lg and above of a 32-bit word
  function automatic logic [31:0] ones_from(input int unsigned lg);
    if (lg >= 32) return 32'h0;
    return 32'hFFFF_FFFF << lg;
  endfunction

  // region size exponent after applying the per-kind minimum
  function automatic int unsigned eff_log2(input int unsigned kind, input int unsigned lg);
    if (kind == KIND_IO) return (lg < IO_MIN_LOG2) ? IO_MIN_LOG2 : lg;
    return (lg < MEM_MIN_LOG2) ? MEM_MIN_LOG2 : lg;
  endfunction

  // writable address bits of one base slot
  function automatic logic [31:0] slot_amask(input int unsigned kind, input int unsigned lg,
                                             input bit high);
    if (high) begin
      if (eff_log2(KIND_MEM64, lg) <= 32) return 32'hFFFF_FFFF;
      return ones_from(eff_log2(KIND_MEM64, lg) - 32);
    end
    if (kind == KIND_NONE) return 32'h0;
    return ones_from(eff_log2(kind, lg));
  endfunction

  // constant type bits of one base slot
  function automatic logic [31:0] slot_fixed(input int unsigned kind, input bit high);
    if (high) return 32'h0;
    if (kind == KIND_IO) return 32'h1;
    if (kind == KIND_MEM64) return 32'h4;
    return 32'h0;
  endfunction

  function automatic logic [31:0] rom_amask(input int unsigned lg);
    return ones_from((lg < ROM_MIN_LOG2) ? ROM_MIN_LOG2 : lg);
  endfunction

  function automatic logic [63:0] region_len(input int unsigned lg);
    return 64'd1 << lg;
  endfunction

endpackage

// File: rtl/barfile_slot.sv
module barfile_slot #(
  parameter logic [31:0] WMASK = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  output logic [31:0] live,
  output logic [31:0] merged
);
  localparam int unsigned LANES = 4;

  logic [31:0] lane_mask;

  always_comb begin
    for (int b = 0; b < LANES; b++) lane_mask[b*8 +: 8] = {8{be[b]}};
  end

  // value the slot would hold after this write
  assign merged = ((live & ~lane_mask) | (wdata & lane_mask)) & WMASK;

  always_ff @(posedge clk) begin
    if (rst)     live <= 32'h0;
    else if (wr) live <= merged;
  end
endmodule

// File: rtl/barfile_region.sv
module barfile_region #(
  parameter logic [31:0] LO_AMASK = 32'hFFFF_F000,
  parameter logic [31:0] HI_AMASK = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        trig,
  input  logic [31:0] lo_val,
  input  logic [31:0] hi_val,
  output logic        ev,
  output logic [63:0] old_base,
  output logic [63:0] new_base
);
  logic [63:0] committed;
  logic [31:0] lo_addr, hi_addr;
  logic        probe;

  assign lo_addr  = lo_val & LO_AMASK;
  assign hi_addr  = hi_val & HI_AMASK;
  // probe only when every writable bit of the whole region is set
  assign probe    = (lo_addr == LO_AMASK) && (hi_addr == HI_AMASK);
  assign new_base = {hi_addr, lo_addr};
  assign old_base = committed;
  assign ev       = trig && !probe && (new_base != committed);

  always_ff @(posedge clk) begin
    if (rst)     committed <= 64'h0;
    else if (ev) committed <= new_base;
  end
endmodule

// File: rtl/barfile_top.sv
module barfile_top
  import barfile_pkg::*;
#(
  parameter int unsigned BAR_KIND [6] = '{KIND_MEM32, KIND_IO, KIND_MEM64, KIND_NONE, KIND_NONE, KIND_MEM32},
  parameter int unsigned BAR_LOG2 [6] = '{12, 8, 20, 0, 0, 16},
  parameter int unsigned ROM_LOG2     = 15
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [2:0]  cfg_idx,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_be,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        reloc_valid,
  output logic [2:0]  reloc_idx,
  output logic [63:0] reloc_old,
  output logic [63:0] reloc_new,
  output logic [63:0] reloc_len
);
  localparam int unsigned NUM_SLOTS = 6;
  localparam int unsigned ROM_IDX   = NUM_SLOTS;
  localparam int unsigned NUM_REG   = NUM_SLOTS + 1;
  localparam int unsigned IDX_W     = $clog2(NUM_REG + 1);
  localparam int unsigned ROM_EFF   = (ROM_LOG2 < ROM_MIN_LOG2) ? ROM_MIN_LOG2 : ROM_LOG2;

  logic [31:0] live   [NUM_REG];
  logic [31:0] merged [NUM_REG];
  logic [31:0] rdv    [NUM_REG];
  logic        slot_wr[NUM_REG];
  logic        ev     [NUM_REG];
  logic [63:0] oldb   [NUM_REG];
  logic [63:0] newb   [NUM_REG];
  logic [63:0] lenv   [NUM_REG];

  for (genvar s = 0; s < NUM_REG; s++) begin : g_dec
    assign slot_wr[s] = cfg_wr && (cfg_idx == IDX_W'(s));
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int unsigned PREV = (s > 0) ? s - 1 : 0;
    localparam bit          HIGH = (s > 0) && (BAR_KIND[PREV] == KIND_MEM64);
    localparam int unsigned KIND = HIGH ? KIND_MEM64 : BAR_KIND[s];
    localparam int unsigned LG   = HIGH ? BAR_LOG2[PREV] : BAR_LOG2[s];
    localparam logic [31:0] AMSK = slot_amask(KIND, LG, HIGH);
    localparam logic [31:0] FIX  = slot_fixed(KIND, HIGH);

    barfile_slot #(.WMASK(AMSK)) u_slot (
      .clk(clk), .rst(rst), .wr(slot_wr[s]), .wdata(cfg_wdata), .be(cfg_be),
      .live(live[s]), .merged(merged[s])
    );
    assign rdv[s]  = live[s] | FIX;
    assign lenv[s] = region_len(eff_log2(KIND, LG));

    if (!HIGH && (KIND == KIND_IO || KIND == KIND_MEM32)) begin : g_r32
      barfile_region #(.LO_AMASK(AMSK), .HI_AMASK(32'h0)) u_region (
        .clk(clk), .rst(rst), .trig(slot_wr[s]), .lo_val(merged[s]), .hi_val(32'h0),
        .ev(ev[s]), .old_base(oldb[s]), .new_base(newb[s])
      );
    end else if (!HIGH && KIND == KIND_MEM64) begin : g_r64
      // a pair is judged when its upper half is written
      barfile_region #(.LO_AMASK(AMSK), .HI_AMASK(slot_amask(KIND_MEM64, LG, 1'b1))) u_region (
        .clk(clk), .rst(rst), .trig(slot_wr[s+1]), .lo_val(live[s]), .hi_val(merged[s+1]),
        .ev(ev[s]), .old_base(oldb[s]), .new_base(newb[s])
      );
    end else begin : g_noreg
      assign ev[s]   = 1'b0;
      assign oldb[s] = 64'h0;
      assign newb[s] = 64'h0;
    end
  end

  // expansion ROM: bit 0 enable, address above the size, reserved bits zero
  barfile_slot #(.WMASK(rom_amask(ROM_LOG2) | 32'h1)) u_rom_slot (
    .clk(clk), .rst(rst), .wr(slot_wr[ROM_IDX]), .wdata(cfg_wdata), .be(cfg_be),
    .live(live[ROM_IDX]), .merged(merged[ROM_IDX])
  );
  assign rdv[ROM_IDX]  = live[ROM_IDX];
  assign lenv[ROM_IDX] = region_len(ROM_EFF);

  barfile_region #(.LO_AMASK(rom_amask(ROM_LOG2)), .HI_AMASK(32'h0)) u_rom_region (
    .clk(clk), .rst(rst), .trig(slot_wr[ROM_IDX]), .lo_val(merged[ROM_IDX]), .hi_val(32'h0),
    .ev(ev[ROM_IDX]), .old_base(oldb[ROM_IDX]), .new_base(newb[ROM_IDX])
  );

  // at most one write per cycle, so at most one event source
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [63:0]       hit_old, hit_new, hit_len;
  logic [31:0]       rd_next;

  always_comb begin
    hit = 1'b0; hit_idx = '0; hit_old = '0; hit_new = '0; hit_len = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (ev[r]) begin
        hit = 1'b1; hit_idx = IDX_W'(r);
        hit_old = oldb[r]; hit_new = newb[r]; hit_len = lenv[r];
      end
    end
  end

  always_comb begin
    rd_next = 32'h0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (cfg_idx == IDX_W'(r)) rd_next = rdv[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      rd_data     <= 32'h0;
      reloc_valid <= 1'b0;
      reloc_idx   <= '0;
      reloc_old   <= '0;
      reloc_new   <= '0;
      reloc_len   <= '0;
    end else begin
      rd_valid    <= cfg_rd;
      if (cfg_rd) rd_data <= rd_next;
      reloc_valid <= hit;
      if (hit) begin
        reloc_idx <= hit_idx;
        reloc_old <= hit_old;
        reloc_new <= hit_new;
        reloc_len <= hit_len;
      end
    end
  end
endmodule

// File: rtl/barfile_chk.sv
module barfile_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_wr,
  input logic        cfg_rd,
  input logic [2:0]  cfg_idx,
  input logic [31:0] cfg_wdata,
  input logic [3:0]  cfg_be,
  input logic        rd_valid,
  input logic        reloc_valid,
  input logic [2:0]  reloc_idx,
  input logic [63:0] reloc_old,
  input logic [63:0] reloc_new,
  input logic [63:0] reloc_len
);
  assert_read_answers_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |=> rd_valid);

  assert_no_stray_read_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> !rd_valid);

  assert_event_needs_write_R7: assert property (@(posedge clk) disable iff (rst)
    reloc_valid |-> $past(cfg_wr));

  assert_event_is_move_R7: assert property (@(posedge clk) disable iff (rst)
    reloc_valid |-> (reloc_old != reloc_new));

  assert_len_pow2_R7: assert property (@(posedge clk) disable iff (rst)
    reloc_valid |-> ($countones(reloc_len) == 1));

  assert_base_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    reloc_valid |-> ((reloc_new & (reloc_len - 64'd1)) == 64'd0));

  assert_rom_probe_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_idx == 3'd6 && cfg_be == 4'hF && cfg_wdata[31:11] == '1) |=> !reloc_valid);

  assert_empty_index_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_idx == 3'd7) |=> !reloc_valid);

  assert_valid_index_R7: assert property (@(posedge clk) disable iff (rst)
    reloc_valid |-> (reloc_idx != 3'd7));
endmodule

bind barfile_top barfile_chk u_chk (.*);

// File: tb/tb_barfile_top.sv
`timescale 1ns/1ps
module tb_barfile_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic        rd_valid, reloc_valid;
  logic [31:0] rd_data;
  logic [2:0]  reloc_idx;
  logic [63:0] reloc_old, reloc_new, reloc_len;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  logic [31:0] q_rd[$];
  string       q_rd_tag[$];
  logic [2:0]  q_ev_idx[$];
  logic [63:0] q_ev_old[$], q_ev_new[$], q_ev_len[$];
  string       q_ev_tag[$];

  always #2.5 clk = ~clk;

  barfile_top dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .reloc_valid(reloc_valid), .reloc_idx(reloc_idx), .reloc_old(reloc_old),
    .reloc_new(reloc_new), .reloc_len(reloc_len)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] idx, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    q_rd.push_back(exp); q_rd_tag.push_back(tag);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_idx = idx;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic expect_move(input logic [2:0] idx, input logic [63:0] o, input logic [63:0] n,
                             input logic [63:0] l, input string tag);
    q_ev_idx.push_back(idx); q_ev_old.push_back(o); q_ev_new.push_back(n);
    q_ev_len.push_back(l); q_ev_tag.push_back(tag);
  endtask

  // monitor: compares outputs against the expectation queues
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (rd_valid) begin
        if (q_rd.size() == 0) check("R10 unexpected read data", 64'(rd_data), 64'hX);
        else begin
          automatic logic [31:0] e = q_rd.pop_front();
          automatic string t = q_rd_tag.pop_front();
          check(t, 64'(rd_data), 64'(e));
        end
      end
      if (reloc_valid) begin
        if (q_ev_idx.size() == 0) begin
          n_checks++; n_errors++;
          $display("FAIL R7 unexpected relocation actual idx=%0d new=%h expected none",
                   reloc_idx, reloc_new);
        end else begin
          automatic string t = q_ev_tag.pop_front();
          check({t, " idx"}, 64'(reloc_idx), 64'(q_ev_idx.pop_front()));
          check({t, " old"}, reloc_old, q_ev_old.pop_front());
          check({t, " new"}, reloc_new, q_ev_new.pop_front());
          check({t, " len"}, reloc_len, q_ev_len.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 R2: reset state
    do_read(3'd0, 32'h0000_0000, "R1 reset mem32");
    do_read(3'd1, 32'h0000_0001, "R1 R2 reset io");
    do_read(3'd2, 32'h0000_0004, "R1 R2 reset mem64 low");
    do_read(3'd3, 32'h0000_0000, "R1 reset mem64 high");
    do_read(3'd5, 32'h0000_0000, "R1 reset mem32 b");
    do_read(3'd6, 32'h0000_0000, "R1 reset rom");

    // R3 R7: 32-bit memory slot, 4 KiB
    expect_move(3'd0, 64'h0, 64'h1234_5000, 64'h1000, "R7 first program");
    do_write(3'd0, 32'h1234_5678, 4'hF);
    do_read(3'd0, 32'h1234_5000, "R3 low bits masked");
    // R4: probe then restore
    do_write(3'd0, 32'hFFFF_FFFF, 4'hF);
    do_read(3'd0, 32'hFFFF_F000, "R4 probe size mask");
    do_write(3'd0, 32'h1234_5000, 4'hF);
    do_read(3'd0, 32'h1234_5000, "R4 restore no move");
    expect_move(3'd0, 64'h1234_5000, 64'h1234_6000, 64'h1000, "R7 move");
    do_write(3'd0, 32'h1234_6000, 4'hF);

    // R2: I/O slot, 256 bytes
    expect_move(3'd1, 64'h0, 64'hABCD_EF00, 64'h100, "R7 io program");
    do_write(3'd1, 32'hABCD_EF03, 4'hF);
    do_read(3'd1, 32'hABCD_EF01, "R2 io type bits");

    // R5: 64-bit pair at 2/3, 1 MiB
    do_write(3'd2, 32'h8010_0000, 4'hF);
    do_read(3'd2, 32'h8010_0004, "R5 low half alone no event");
    expect_move(3'd2, 64'h0, 64'h2_8010_0000, 64'h10_0000, "R5 pair program");
    do_write(3'd3, 32'h0000_0002, 4'hF);
    do_write(3'd2, 32'hFFFF_FFFF, 4'hF);
    do_write(3'd3, 32'hFFFF_FFFF, 4'hF);
    do_read(3'd2, 32'hFFF0_0004, "R5 probe low");
    do_read(3'd3, 32'hFFFF_FFFF, "R5 probe high");
    do_write(3'd2, 32'h8010_0000, 4'hF);
    do_write(3'd3, 32'h0000_0002, 4'hF);
    do_read(3'd3, 32'h0000_0002, "R5 restore no move");
    expect_move(3'd2, 64'h2_8010_0000, 64'hFFFF_FFFF_8010_0000, 64'h10_0000, "R5 ones high real low");
    do_write(3'd3, 32'hFFFF_FFFF, 4'hF);
    do_write(3'd2, 32'hFFFF_FFFF, 4'hF);
    expect_move(3'd2, 64'hFFFF_FFFF_8010_0000, 64'h5_FFF0_0000, 64'h10_0000, "R5 ones low real high");
    do_write(3'd3, 32'h0000_0005, 4'hF);

    // R6: expansion ROM, 32 KiB
    expect_move(3'd6, 64'h0, 64'h0004_8000, 64'h8000, "R6 rom program");
    do_write(3'd6, 32'h0004_8001, 4'hF);
    do_read(3'd6, 32'h0004_8001, "R6 rom enable set");
    do_write(3'd6, 32'hFFFF_F800, 4'hF);
    do_read(3'd6, 32'hFFFF_8000, "R6 rom probe");
    do_write(3'd6, 32'h0004_83FE, 4'hF);
    do_read(3'd6, 32'h0004_8000, "R6 reserved bits zero");

    // R8: unused slot and empty index
    do_write(3'd4, 32'h1234_5678, 4'hF);
    do_read(3'd4, 32'h0000_0000, "R8 unused slot");
    do_write(3'd7, 32'hFFFF_FFFF, 4'hF);
    do_read(3'd7, 32'h0000_0000, "R8 empty index");
    do_read(3'd0, 32'h1234_6000, "R8 neighbour untouched");

    // R9: byte lanes on slot 5, 64 KiB
    expect_move(3'd5, 64'h0, 64'h00AA_0000, 64'h1_0000, "R9 lane 2");
    do_write(3'd5, 32'h00AA_0000, 4'b0100);
    expect_move(3'd5, 64'h00AA_0000, 64'hFFAA_0000, 64'h1_0000, "R9 lane 3");
    do_write(3'd5, 32'hFF00_0000, 4'b1000);
    do_write(3'd5, 32'h00FF_0000, 4'b0100);
    do_read(3'd5, 32'hFFFF_0000, "R9 partial probe");
    do_write(3'd5, 32'h0000_FFFF, 4'b0011);
    do_read(3'd5, 32'hFFFF_0000, "R9 R3 low lanes masked");
    expect_move(3'd5, 64'hFFAA_0000, 64'h1234_0000, 64'h1_0000, "R9 upper lanes move");
    do_write(3'd5, 32'h1234_0000, 4'b1100);
    do_read(3'd5, 32'h1234_0000, "R9 final");

    repeat (4) @(negedge clk);
    check("R10 reads outstanding", 64'(q_rd.size()), 64'd0);
    check("R7 events outstanding", 64'(q_ev_idx.size()), 64'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule